// File: doc/BRIEF.md
# Diagonally Pipelined Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. The datapath is a square grid of identical cells. Each cell ANDs one bit of each operand and adds that bit into a running sum with a full adder. Sum bits move down from one row to the next, and carries move across each row toward the more significant end.

Pipeline registers cut the grid along diagonals. The cell in row r and column c is evaluated in stage 2r+c. Every cell therefore reads only registered values, so each stage is one cell deep whatever N is. Operand bits travel through skew registers, so each diagonal sees the bits of its own operand pair. The stage count grows linearly with N. A new pair can be accepted on every clock, and one product leaves per clock.

A valid flag marks each operand pair. The flag is delayed by exactly the pipeline depth, so the output flag rises on the cycle the matching product appears. The block has no stall input.

Top module: `diag_array_mult`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the unsigned product of the `in_a` and `in_b` values of the matching accepted pair, zero-extended to 2N bits.
- R2: A pair is captured on the rising edge where `in_valid` is high. Its product and `out_valid` appear after the 3N-2 rising edges that follow the capture edge (22 edges for N=8).
- R3: A pair can be accepted on every clock. Pairs accepted on consecutive edges produce results on consecutive cycles, in the order they were accepted, and no result is lost.
- R4: `out_valid` is high only in cycles that correspond to an accepted pair. Idle cycles in the input stream appear as low `out_valid` cycles in the same positions.
- R5: A synchronous active-high `rst` discards every pair in flight. `out_valid` is low from the first edge of reset until a pair accepted after reset comes out.
- R6: Corner operands give exact products: zero times any value gives 0, all-ones times all-ones gives 2^(2N) - 2^(N+1) + 1, and a power of two times a value gives that value shifted left.
- R7: When `in_valid` is low, `in_a` and `in_b` have no effect: changing them in idle cycles alters neither `out_valid` nor any later product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks an operand pair to be captured |
| in_a | input | N | Multiplicand, unsigned |
| in_b | input | N | Multiplier, unsigned |
| out_valid | output | 1 | Marks a finished product |
| out_prod | output | 2N | Unsigned product |

## Verification
The scoreboard records, for every pair it sends, the cycle in which the result is due. A latency off by one register, or a skew tap misaligned on one diagonal, therefore shows up as a mismatched or missing result instead of passing unnoticed. All-ones operands drive a carry through every row, including the row-end carry that needs an extra register. If that register were missing, the upper product bits would be wrong only for such operands. Random junk on idle cycles and a reset issued while pairs are in flight catch a design that samples operands without the valid flag or keeps stale flags after reset, because either fault raises `out_valid` with no pair behind it.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

    // Outputs of one grid cell.
    typedef struct packed {
        logic sum;
        logic carry;
    } cell_out_t;

    // Pipeline stage in which the cell at (row, col) is evaluated.
    function automatic int cell_stage(input int row, input int col);
        return 2 * row + col;
    endfunction

    // Number of rising edges from operand capture to a visible product.
    function automatic int pipe_latency(input int n);
        return 3 * n - 2;
    endfunction

    // Extra registers a cell output needs to line up with the final edge.
    function automatic int align_depth(input int n, input int row, input int col);
        return pipe_latency(n) - cell_stage(row, col) - 1;
    endfunction

endpackage

// File: rtl/mpa_cell.sv
module mpa_cell
    import mpa_pkg::*;
(
    input  logic      a_bit,
    input  logic      b_bit,
    input  logic      sum_in,
    input  logic      carry_in,
    output cell_out_t res
);
    logic pp;

    always_comb begin
        pp        = a_bit & b_bit;
        res.sum   = pp ^ sum_in ^ carry_in;
        res.carry = (pp & sum_in) | (pp & carry_in) | (sum_in & carry_in);
    end
endmodule

// File: rtl/mpa_skew.sv
module mpa_skew #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [W-1:0]              din,
    output logic [DEPTH-1:0][W-1:0]   taps
);
    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else begin
            taps[0] <= din;
            for (int k = 1; k < DEPTH; k++) begin
                taps[k] <= taps[k-1];
            end
        end
    end
endmodule

// File: rtl/mpa_delay.sv
module mpa_delay #(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    if (DEPTH == 0) begin : g_wire
        assign q = d;
    end else begin : g_regs
        logic [DEPTH-1:0] sr;
        always_ff @(posedge clk) begin
            if (rst) begin
                sr <= '0;
            end else begin
                sr[0] <= d;
                for (int k = 1; k < DEPTH; k++) begin
                    sr[k] <= sr[k-1];
                end
            end
        end
        assign q = sr[DEPTH-1];
    end
endmodule

// File: rtl/diag_array_mult.sv
module diag_array_mult
    import mpa_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [N-1:0]   in_a,
    input  logic [N-1:0]   in_b,
    output logic           out_valid,
    output logic [2*N-1:0] out_prod
);
    localparam int LAT = pipe_latency(N);
    localparam int PW  = 2 * N;

    // Operand skew lines: tap t holds the pair captured t edges ago.
    logic [LAT-1:0][N-1:0] a_taps;
    logic [LAT-1:0][N-1:0] b_taps;

    mpa_skew #(.W(N), .DEPTH(LAT)) u_skew_a (
        .clk(clk), .rst(rst), .din(in_a), .taps(a_taps)
    );
    mpa_skew #(.W(N), .DEPTH(LAT)) u_skew_b (
        .clk(clk), .rst(rst), .din(in_b), .taps(b_taps)
    );

    // Registered cell outputs and row-end carry extensions.
    cell_out_t cell_q [N][N];
    logic      row_co [N-1];
    logic [PW-1:0] prod_w;

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            localparam int T = cell_stage(r, c);
            logic      s_in;
            logic      c_in;
            cell_out_t nx;
            cell_out_t q;

            if (r == 0) begin : g_top
                assign s_in = 1'b0;
            end else if (c == N - 1) begin : g_edge
                assign s_in = row_co[r-1];
            end else begin : g_inner
                assign s_in = cell_q[r-1][c+1].sum;
            end

            if (c == 0) begin : g_lsb
                assign c_in = 1'b0;
            end else begin : g_chain
                assign c_in = cell_q[r][c-1].carry;
            end

            mpa_cell u_cell (
                .a_bit    (a_taps[T][r]),
                .b_bit    (b_taps[T][c]),
                .sum_in   (s_in),
                .carry_in (c_in),
                .res      (nx)
            );

            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= nx;
            end
            assign cell_q[r][c] = q;

            // Product bit taps, each delayed to the final stage.
            if (r < N - 1 && c == 0) begin : g_low_bit
                mpa_delay #(.DEPTH(align_depth(N, r, 0))) u_align (
                    .clk(clk), .rst(rst), .d(q.sum), .q(prod_w[r])
                );
            end else if (r == N - 1) begin : g_high_bit
                mpa_delay #(.DEPTH(align_depth(N, r, c))) u_align (
                    .clk(clk), .rst(rst), .d(q.sum), .q(prod_w[N-1+c])
                );
            end
        end

        // Carry out of a row enters the next row one stage later.
        if (r < N - 1) begin : g_row_carry
            logic co_q;
            always_ff @(posedge clk) begin
                if (rst) co_q <= 1'b0;
                else     co_q <= cell_q[r][N-1].carry;
            end
            assign row_co[r] = co_q;
        end
    end

    assign prod_w[PW-1] = cell_q[N-1][N-1].carry;

    mpa_delay #(.DEPTH(LAT + 1)) u_valid (
        .clk(clk), .rst(rst), .d(in_valid), .q(out_valid)
    );

    assign out_prod = prod_w;
endmodule

// File: rtl/mpa_chk.sv
module mpa_chk
    import mpa_pkg::*;
#(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [N-1:0]   in_a,
    input logic [N-1:0]   in_b,
    input logic           out_valid,
    input logic [2*N-1:0] out_prod
);
    localparam int LAT = pipe_latency(N);
    localparam int PW  = 2 * N;

    logic [LAT:0]  v_pipe;
    logic [PW-1:0] p_pipe [LAT+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            v_pipe <= '0;
            for (int k = 0; k <= LAT; k++) p_pipe[k] <= '0;
        end else begin
            v_pipe    <= {v_pipe[LAT-1:0], in_valid};
            p_pipe[0] <= PW'(in_a) * PW'(in_b);
            for (int k = 1; k <= LAT; k++) p_pipe[k] <= p_pipe[k-1];
        end
    end

    // R1
    product_value_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_prod == p_pipe[LAT]));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_pipe[LAT]);

    // R3
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && v_pipe[LAT-1]) |=> out_valid);

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

bind diag_array_mult mpa_chk #(.N(N)) u_chk (.*);

// File: tb/sim_diag_array_mult.sv
module sim_diag_array_mult;
    localparam int N   = 8;
    localparam int PW  = 2 * N;
    localparam int LAT = 3 * N - 2;   // from R2

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [N-1:0]  in_a = '0;
    logic [N-1:0]  in_b = '0;
    logic          out_valid;
    logic [PW-1:0] out_prod;

    always #4 clk = ~clk;   // 125 MHz

    diag_array_mult #(.N(N)) u0 (.*);

    typedef struct {
        logic [PW-1:0] prod;
        int unsigned   due;
    } exp_t;

    exp_t        sb[$];
    int unsigned cyc = 0;
    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned seen = 0;
    int unsigned issued = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [N-1:0] a, input logic [N-1:0] b);
        exp_t e;
        @(posedge clk); #2;
        in_valid = 1'b1;
        in_a = a;
        in_b = b;
        e.prod = PW'(a) * PW'(b);
        e.due  = cyc + 1 + LAT;
        sb.push_back(e);
        issued++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #2;
            in_valid = 1'b0;
            in_a = N'($urandom);   // R7: junk while idle
            in_b = N'($urandom);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin : mon
        exp_t e;
        if (!rst) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R4", "out_valid without pair", 1, 0);
                end else begin
                    e = sb.pop_front();
                    seen++;
                    chk(out_prod == e.prod, "R1", "product", out_prod, e.prod);
                    chk(cyc == e.due, "R2", "result cycle", cyc, e.due);
                end
            end else if (sb.size() != 0 && sb[0].due == cyc) begin
                chk(1'b0, "R2", "result missing at due cycle", 0, 1);
                void'(sb.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R5", "reset state", out_valid, 0);
        @(posedge clk); #2;
        rst = 1'b0;

        // R6 corner operands, back to back
        send(8'h00, 8'h00);
        send(8'hFF, 8'hFF);
        send(8'h01, 8'hFF);
        send(8'hFF, 8'h01);
        send(8'h80, 8'h80);
        send(8'hAA, 8'h55);
        send(8'h55, 8'hAA);
        send(8'hFF, 8'h00);
        send(8'h01, 8'h01);
        send(8'h10, 8'hC3);
        idle(5);

        // R4 gaps of varying length, R7 junk during gaps
        for (int k = 0; k < 20; k++) begin
            send(N'(k * 13 + 1), N'(k * 7 + 3));
            idle(k % 4);
        end

        // R3 long back-to-back random stream
        for (int k = 0; k < 300; k++) begin
            send(N'($urandom), N'($urandom));
        end
        idle(LAT + 4);
        chk(sb.size() == 0, "R3", "queue drained", sb.size(), 0);
        chk(seen == issued, "R3", "results delivered", seen, issued);

        // R5 reset with pairs in flight
        for (int k = 0; k < 10; k++) send(8'hFF, N'(k));
        @(posedge clk); #2;
        rst = 1'b1;
        in_valid = 1'b0;
        sb.delete();
        issued = seen;
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
        for (int k = 0; k < LAT + 3; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R5", "flushed after reset", out_valid, 0);
        end

        // Operation after reset
        send(8'hFF, 8'hFF);
        send(8'h02, 8'h81);
        idle(2);
        send(8'h7F, 8'hFE);
        idle(LAT + 4);
        chk(sb.size() == 0, "R3", "queue drained after reset", sb.size(), 0);
        chk(seen == issued, "R3", "results after reset", seen, issued);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule